// File: doc/BRIEF.md
# Video-Mode Line Packet Scheduler

This block decides which display-serial-interface packets a video-mode host sends on each line and how long each one is. A table of twelve programmable schedule words is walked one word per line. Each word can name up to three packets and can ask for the link to drop to the low-power state once its packets are out. The block emits one command per packet, carrying the packet data type, its byte length and a flag that marks the last packet before a low-power return. The commands go to a downstream packet engine over a valid/ready handshake.

Packet lengths are not stored in the schedule words. Each slot holds a 3-bit index into an eight-entry length table. The block fills that table from the horizontal timing of the panel, given in pixels. Each timing figure is scaled to bytes for the chosen pixel format, and the framing overhead of each blanking packet is subtracted. The block also outputs the start-of-line delay in byte clocks for the chosen format.

The schedule table, the timing inputs and the format are captured only while the block is disabled. While it is enabled they are frozen, so a running line schedule never sees a half-updated configuration.

Top module: `pktseq_gen`

## Requirements
- R1: A schedule word has three slots, decoded at fixed bit positions. Slot k (k = 0, 1, 2) takes its length index from bits 10k+2..10k, its 6-bit data type from bits 10k+8..10k+3, and its enable from bit 10k+9. Enabled slots of a word are emitted in slot order 0, 1, 2, and disabled slots are skipped.
- R2: When bit 30 of a word is set, `cmd_lp` is 1 on the last emitted command of that word and 0 on all of its other commands. When bit 30 is clear, `cmd_lp` is 0 on every command of that word.
- R3: A word with all three enables clear emits no command, yet it still uses up one line strobe.
- R4: Raising `en` starts word 0 without a strobe. Each later `line_strobe` moves to the next word, and word 11 is followed by word 0. A strobe that arrives while a word is still being emitted is held and acted on once that word is done.
- R5: The length index selects the byte length as follows: 0 gives 0, 1 gives sync, 2 gives back porch, 3 gives active, 4 gives front porch, 5 gives 0, and 6 and 7 both give 15.
- R6: Pixel counts are scaled to bytes by the `fmt` code. Codes 0 and 1 multiply by 3, code 2 multiplies by 2, and code 3 gives 9×px/4 rounded down.
- R7: When `pulse_mode` is 0, the scaled sync width is added to the back porch. The sync, back-porch and front-porch lengths then have 10, 14 and 8 subtracted, with the result held at 0 if it would go negative.
- R8: `sol_delay` equals 8 × mul / div for the format: 24 for codes 0 and 1, 16 for code 2, and 18 for code 3.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, the command stays valid and its data type, length and low-power flag hold steady.
- R10: Table writes and changes to the timing, format or mode inputs have no effect while `en` is 1.
- R11: One cycle after `en` falls, `cmd_valid` is 0. The next rise of `en` restarts the schedule from word 0.
- R12: After reset, `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; also locks the configuration |
| line_strobe | input | 1 | One-cycle pulse at each line start |
| tbl_we | input | 1 | Schedule word write strobe |
| tbl_addr | input | 4 | Schedule word index 0..11 |
| tbl_data | input | 31 | Schedule word |
| fmt | input | 2 | Pixel format code (R6) |
| pulse_mode | input | 1 | 1: separate sync packets, 0: sync folded into back porch |
| hsync_px | input | 12 | Sync width in pixels |
| hbp_px | input | 12 | Back porch in pixels |
| hact_px | input | 12 | Active width in pixels |
| hfp_px | input | 12 | Front porch in pixels |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by downstream |
| cmd_dtype | output | 6 | Packet data type |
| cmd_len | output | 16 | Packet length in bytes |
| cmd_lp | output | 1 | Return to low power after this packet |
| sol_delay | output | 16 | Start-of-line delay in byte clocks |

## Verification
The scheduler is run with three kinds of table.

- A pulse-style table with full and sparse words, including a word whose only enabled slot is slot 2 and one whose only enabled slot is slot 1. This shows that slot order, slot skipping and the placement of the low-power flag are all decoded correctly.
- An event-style table in the 9/4 format with a sync width small enough that its length saturates. This separates folding from non-folding and saturation from wrap-around.
- A 2/1 format run, which shows that the scale factor is chosen by the format code.

Across these runs the downstream ready line is held high in some phases and toggled in others. Strobes come after the line has drained in some cases and in the middle of emission in others, which separates a held strobe from a lost one. Writes and timing changes made while enabled, followed by a disable in the middle of a stall, show that the frozen configuration is kept and that the schedule restarts cleanly.

// File: rtl/pktseq_pkg.sv
package pktseq_pkg;

    localparam int ENT_W     = 31;   // schedule word width (bit 30 = low-power request)
    localparam int SLOTS     = 3;
    localparam int SLOT_W    = 10;
    localparam int N_LEN     = 8;
    localparam int LI_W      = $clog2(N_LEN);
    localparam int DT_W      = 6;
    localparam int LEN_W     = 16;
    localparam int LP_BIT    = 30;
    localparam int OVH_SYNC  = 10;
    localparam int OVH_BP    = 14;
    localparam int OVH_FP    = 8;
    localparam int FIX_LEN   = 15;
    localparam int SOL_BASE  = 8;

    typedef enum logic [1:0] {
        FMT_RGB24  = 2'd0,
        FMT_RGB18P = 2'd1,
        FMT_RGB16  = 2'd2,
        FMT_RGB18L = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic            on;
        logic [DT_W-1:0] dtype;
        logic [LI_W-1:0] lidx;
    } slot_t;

    typedef struct packed {
        logic [DT_W-1:0]  dtype;
        logic [LEN_W-1:0] len;
        logic             lp;
    } cmd_t;

    function automatic slot_t get_slot(input logic [ENT_W-1:0] w, input int k);
        slot_t s;
        s.lidx  = w[k*SLOT_W +: LI_W];
        s.dtype = w[k*SLOT_W + LI_W +: DT_W];
        s.on    = w[k*SLOT_W + LI_W + DT_W];
        return s;
    endfunction

    // bytes = px * mul / div for the selected pixel format
    function automatic logic [LEN_W-1:0] scale_px(input pix_fmt_e f, input logic [LEN_W-1:0] px);
        logic [LEN_W+3:0] p;
        case (f)
            FMT_RGB16:  p = {4'd0, px} << 1;
            FMT_RGB18L: p = ({4'd0, px} * (LEN_W+4)'(9)) >> 2;
            default:    p = {4'd0, px} * (LEN_W+4)'(3);
        endcase
        return p[LEN_W-1:0];
    endfunction

    function automatic logic [LEN_W-1:0] sat_sub(input logic [LEN_W-1:0] a, input int b);
        return (a > LEN_W'(b)) ? a - LEN_W'(b) : '0;
    endfunction

    function automatic logic [LEN_W-1:0] sol_of(input pix_fmt_e f);
        return scale_px(f, LEN_W'(SOL_BASE));
    endfunction

endpackage

// File: rtl/pktseq_table.sv
module pktseq_table
    import pktseq_pkg::*;
#(
    parameter int N_ENT = 12,
    parameter int AW    = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [ENT_W-1:0] rd_word
);

    logic [ENT_W-1:0] ent [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (!lock && wr_en && (int'(wr_addr) == g))
                ent[g] <= wr_data;
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_addr) < N_ENT)
            rd_word = ent[rd_addr];
    end

endmodule

// File: rtl/pktseq_lenfit.sv
module pktseq_lenfit
    import pktseq_pkg::*;
#(
    parameter int PX_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        lock,
    input  logic [1:0]                  fmt,
    input  logic                        pulse_mode,
    input  logic [PX_W-1:0]             hsync_px,
    input  logic [PX_W-1:0]             hbp_px,
    input  logic [PX_W-1:0]             hact_px,
    input  logic [PX_W-1:0]             hfp_px,
    output logic [N_LEN-1:0][LEN_W-1:0] len_tab,
    output logic [LEN_W-1:0]            sol_dly
);

    pix_fmt_e                    f;
    logic [LEN_W-1:0]            sw, bp, ac, fp, bp_eff;
    logic [N_LEN-1:0][LEN_W-1:0] nxt;

    always_comb begin
        f      = pix_fmt_e'(fmt);
        sw     = scale_px(f, LEN_W'(hsync_px));
        bp     = scale_px(f, LEN_W'(hbp_px));
        ac     = scale_px(f, LEN_W'(hact_px));
        fp     = scale_px(f, LEN_W'(hfp_px));
        bp_eff = pulse_mode ? bp : bp + sw;
        nxt    = '0;
        nxt[1] = sat_sub(sw, OVH_SYNC);
        nxt[2] = sat_sub(bp_eff, OVH_BP);
        nxt[3] = ac;
        nxt[4] = sat_sub(fp, OVH_FP);
        nxt[6] = LEN_W'(FIX_LEN);
        nxt[7] = LEN_W'(FIX_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_tab <= '0;
            sol_dly <= '0;
        end else if (!lock) begin
            len_tab <= nxt;
            sol_dly <= sol_of(f);
        end
    end

endmodule

// File: rtl/pktseq_walker.sv
module pktseq_walker
    import pktseq_pkg::*;
#(
    parameter int N_ENT = 12,
    parameter int AW    = $clog2(N_ENT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        line_strobe,
    input  logic [ENT_W-1:0]            word,
    input  logic [N_LEN-1:0][LEN_W-1:0] len_tab,
    output logic [AW-1:0]               ptr,
    output logic                        pend,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output cmd_t                        cmd
);

    logic       started, active;
    logic [1:0] slot;
    logic       found, more;
    int         pk;
    slot_t      sel;
    logic       out_free;
    logic [AW-1:0] ptr_nx;

    // first enabled slot at or after the current slot, and whether any follows it
    always_comb begin
        found = 1'b0;
        more  = 1'b0;
        pk    = 0;
        for (int k = 0; k < SLOTS; k++) begin
            if (!found && get_slot(word, k).on && (k >= int'(slot))) begin
                found = 1'b1;
                pk    = k;
            end
        end
        for (int k = 0; k < SLOTS; k++) begin
            if (found && (k > pk) && get_slot(word, k).on)
                more = 1'b1;
        end
        sel      = get_slot(word, pk);
        out_free = !cmd_valid || cmd_ready;
        ptr_nx   = (int'(ptr) == N_ENT - 1) ? '0 : ptr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            started   <= 1'b0;
            active    <= 1'b0;
            pend      <= 1'b0;
            ptr       <= '0;
            slot      <= '0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            if (cmd_valid && cmd_ready)
                cmd_valid <= 1'b0;
            if (!started) begin
                started <= 1'b1;
                active  <= 1'b1;
                ptr     <= '0;
                slot    <= '0;
            end else if (active) begin
                if (out_free) begin
                    if (found) begin
                        cmd_valid <= 1'b1;
                        cmd.dtype <= sel.dtype;
                        cmd.len   <= len_tab[sel.lidx];
                        cmd.lp    <= word[LP_BIT] && !more;
                        slot      <= 2'(pk + 1);
                    end else begin
                        active <= 1'b0;
                    end
                end
                if (line_strobe)
                    pend <= 1'b1;
            end else if (line_strobe || pend) begin
                ptr    <= ptr_nx;
                slot   <= '0;
                active <= 1'b1;
                pend   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pktseq_gen.sv
module pktseq_gen
    import pktseq_pkg::*;
#(
    parameter int N_ENT = 12,
    parameter int PX_W  = 12,
    localparam int AW   = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line_strobe,
    input  logic             tbl_we,
    input  logic [AW-1:0]    tbl_addr,
    input  logic [ENT_W-1:0] tbl_data,
    input  logic [1:0]       fmt,
    input  logic             pulse_mode,
    input  logic [PX_W-1:0]  hsync_px,
    input  logic [PX_W-1:0]  hbp_px,
    input  logic [PX_W-1:0]  hact_px,
    input  logic [PX_W-1:0]  hfp_px,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [DT_W-1:0]  cmd_dtype,
    output logic [LEN_W-1:0] cmd_len,
    output logic             cmd_lp,
    output logic [LEN_W-1:0] sol_delay
);

    logic [ENT_W-1:0]            w_word;
    logic [AW-1:0]               w_ptr;
    logic                        w_pend;
    logic [N_LEN-1:0][LEN_W-1:0] w_len;
    cmd_t                        w_cmd;

    pktseq_table #(.N_ENT(N_ENT), .AW(AW)) u_tbl (
        .clk(clk), .rst(rst), .lock(en),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
        .rd_addr(w_ptr), .rd_word(w_word)
    );

    pktseq_lenfit #(.PX_W(PX_W)) u_len (
        .clk(clk), .rst(rst), .lock(en),
        .fmt(fmt), .pulse_mode(pulse_mode),
        .hsync_px(hsync_px), .hbp_px(hbp_px), .hact_px(hact_px), .hfp_px(hfp_px),
        .len_tab(w_len), .sol_dly(sol_delay)
    );

    pktseq_walker #(.N_ENT(N_ENT), .AW(AW)) u_walk (
        .clk(clk), .rst(rst), .en(en), .line_strobe(line_strobe),
        .word(w_word), .len_tab(w_len),
        .ptr(w_ptr), .pend(w_pend),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd(w_cmd)
    );

    assign cmd_dtype = w_cmd.dtype;
    assign cmd_len   = w_cmd.len;
    assign cmd_lp    = w_cmd.lp;

endmodule

// File: rtl/pktseq_chk.sv
module pktseq_chk
    import pktseq_pkg::*;
#(
    parameter int N_ENT = 12,
    parameter int AW    = $clog2(N_ENT)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        en,
    input logic                        line_strobe,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic [DT_W-1:0]             cmd_dtype,
    input logic [LEN_W-1:0]            cmd_len,
    input logic                        cmd_lp,
    input logic [AW-1:0]               ptr,
    input logic                        pend,
    input logic [N_LEN-1:0][LEN_W-1:0] len_tab
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && en) |=>
            (cmd_valid && $stable(cmd_dtype) && $stable(cmd_len) && $stable(cmd_lp))); // R9

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !cmd_valid); // R11

    AST_ADV_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        ((ptr != $past(ptr)) && $past(en) && !$past(rst)) |->
            $past(line_strobe || pend)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((int'($past(ptr)) == N_ENT - 1) && (ptr != $past(ptr)) && !$past(rst)) |->
            (ptr == '0)); // R4

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> $stable(len_tab)); // R10

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < N_ENT); // R4

endmodule

bind pktseq_gen pktseq_chk #(.N_ENT(N_ENT), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .en(en), .line_strobe(line_strobe),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dtype(cmd_dtype), .cmd_len(cmd_len), .cmd_lp(cmd_lp),
    .ptr(w_ptr), .pend(w_pend), .len_tab(w_len)
);

// File: tb/sim_pktseq_gen.sv
module sim_pktseq_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, line_strobe = 1'b0, tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [30:0] tbl_data = '0;
    logic [1:0]  fmt = 2'd0;
    logic        pulse_mode = 1'b1;
    logic [11:0] hsync_px = '0, hbp_px = '0, hact_px = '0, hfp_px = '0;
    logic        cmd_valid, cmd_ready, cmd_lp;
    logic [5:0]  cmd_dtype;
    logic [15:0] cmd_len, sol_delay;

    int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
    logic [30:0] tbl [12];
    int          lens [8];
    int          bptr = 0;
    logic [22:0] q [$];
    string       tq [$];
    string       cur_tag = "R1";

    always #5 clk = ~clk;

    pktseq_gen u0 (
        .clk(clk), .rst(rst), .en(en), .line_strobe(line_strobe),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .fmt(fmt), .pulse_mode(pulse_mode),
        .hsync_px(hsync_px), .hbp_px(hbp_px), .hact_px(hact_px), .hfp_px(hfp_px),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dtype(cmd_dtype),
        .cmd_len(cmd_len), .cmd_lp(cmd_lp), .sol_delay(sol_delay)
    );

    // ready driver
    initial begin
        cmd_ready = 1'b1;
        forever begin
            @(posedge clk); #2;
            cyc++;
            cmd_ready = (rdy_mode == 0) ? 1'b1 : (cyc[0] ^ cyc[2]);
        end
    end

    // monitor / scoreboard
    logic        prev_stall = 1'b0;
    logic [22:0] prev_cmd = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_stall) begin
                    checks++;
                    if (!cmd_valid || {cmd_dtype, cmd_len, cmd_lp} != prev_cmd) begin
                        errors++;
                        $display("FAIL R9 stalled command changed: got v=%0b %h exp %h",
                                 cmd_valid, {cmd_dtype, cmd_len, cmd_lp}, prev_cmd);
                    end
                end
                if (cmd_valid && cmd_ready) begin
                    checks++;
                    if (q.size() == 0) begin
                        errors++;
                        $display("FAIL %s unexpected command: got dt=%h len=%0d lp=%0b exp none",
                                 cur_tag, cmd_dtype, cmd_len, cmd_lp);
                    end else begin
                        logic [22:0] e;
                        string t;
                        e = q.pop_front();
                        t = tq.pop_front();
                        if ({cmd_dtype, cmd_len, cmd_lp} != e) begin
                            errors++;
                            $display("FAIL %s command: got dt=%h len=%0d lp=%0b exp dt=%h len=%0d lp=%0b",
                                     t, cmd_dtype, cmd_len, cmd_lp, e[22:17], e[16:1], e[0]);
                        end
                    end
                end
                prev_stall = cmd_valid && !cmd_ready && en;
                prev_cmd   = {cmd_dtype, cmd_len, cmd_lp};
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: got running exp finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [30:0] mk(input int d0, input int l0, input int e0,
                                       input int d1, input int l1, input int e1,
                                       input int d2, input int l2, input int e2, input int lp);
        logic [30:0] w;
        w = '0;
        w[2:0] = 3'(l0);   w[8:3] = 6'(d0);   w[9] = e0[0];
        w[12:10] = 3'(l1); w[18:13] = 6'(d1); w[19] = e1[0];
        w[22:20] = 3'(l2); w[28:23] = 6'(d2); w[29] = e2[0];
        w[30] = lp[0];
        return w;
    endfunction

    function automatic int bscale(input int f, input int px);
        if (f == 2) return px * 2;
        if (f == 3) return (px * 9) / 4;
        return px * 3;
    endfunction

    function automatic int bsub(input int a, input int b);
        return (a > b) ? a - b : 0;
    endfunction

    task automatic set_timing(input int f, input int pm, input int sw, input int bp,
                              input int ac, input int fp);
        int s, b, a, p;
        fmt = 2'(f); pulse_mode = pm[0];
        hsync_px = 12'(sw); hbp_px = 12'(bp); hact_px = 12'(ac); hfp_px = 12'(fp);
        if (!en) begin
            s = bscale(f, sw); b = bscale(f, bp); a = bscale(f, ac); p = bscale(f, fp);
            if (pm == 0) b = b + s;
            lens[0] = 0; lens[1] = bsub(s, 10); lens[2] = bsub(b, 14); lens[3] = a;
            lens[4] = bsub(p, 8); lens[5] = 0; lens[6] = 15; lens[7] = 15;
        end
    endtask

    task automatic wr_entry(input int i, input logic [30:0] w);
        @(posedge clk); #2;
        tbl_we = 1'b1; tbl_addr = 4'(i); tbl_data = w;
        @(posedge clk); #2;
        tbl_we = 1'b0;
        if (!en) tbl[i] = w;
    endtask

    task automatic push_entry(input int i);
        logic [30:0] w;
        int last;
        w = tbl[i];
        last = -1;
        for (int k = 0; k < 3; k++) if (w[10*k+9]) last = k;
        for (int k = 0; k < 3; k++) begin
            if (w[10*k+9]) begin
                q.push_back({w[10*k+3 +: 6], 16'(lens[w[10*k +: 3]]), w[30] && (k == last)});
                tq.push_back(cur_tag);
            end
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (q.size() == 0 && !cmd_valid) break;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic start_run();
        bptr = 0;
        push_entry(0);
        @(posedge clk); #2;
        en = 1'b1;
        wait_idle();
    endtask

    task automatic strobe(input bit drain);
        if (drain) wait_idle();
        @(posedge clk); #2;
        bptr = (bptr == 11) ? 0 : bptr + 1;
        push_entry(bptr);
        line_strobe = 1'b1;
        @(posedge clk); #2;
        line_strobe = 1'b0;
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic pulse_table();
        wr_entry(0,  mk(8'h01,0,1, 8'h19,1,1, 8'h31,0,1, 1));
        wr_entry(1,  31'd0);
        wr_entry(2,  mk(8'h11,0,1, 8'h19,1,1, 8'h31,0,1, 1));
        wr_entry(3,  31'd0);
        wr_entry(4,  mk(8'h21,0,1, 8'h19,1,1, 8'h31,0,1, 1));
        wr_entry(5,  mk(0,0,0, 8'h19,6,1, 0,0,0, 0));
        wr_entry(6,  mk(8'h21,0,1, 8'h19,1,1, 8'h31,0,1, 0));
        wr_entry(7,  mk(8'h19,2,1, 8'h3e,3,1, 8'h19,4,1, 0));
        wr_entry(8,  mk(8'h21,0,1, 8'h19,1,1, 8'h31,0,1, 1));
        wr_entry(9,  mk(0,0,0, 0,0,0, 8'h08,7,1, 1));
        wr_entry(10, mk(8'h21,0,1, 0,5,0, 8'h31,0,1, 0));
        wr_entry(11, mk(8'h19,2,1, 8'h3e,3,1, 8'h19,4,1, 0));
    endtask

    initial begin
        // R12 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_val("R12 cmd_valid in reset", int'(cmd_valid), 0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check_val("R12 cmd_valid after reset", int'(cmd_valid), 0);

        // pulse schedule, 3/1 format, ready always high
        pulse_table();
        set_timing(0, 1, 4, 10, 64, 12);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R8 sol_delay fmt0", int'(sol_delay), 24);
        cur_tag = "R1/R2/R5";
        start_run();
        cur_tag = "R3/R4";
        for (int s = 0; s < 13; s++) strobe(1);   // walks 1..11, wraps to 0, then 1

        // R10: writes and timing changes while enabled are ignored
        wait_idle();
        wr_entry(2, mk(8'h2a,3,1, 0,0,0, 0,0,0, 0));
        set_timing(0, 1, 4, 10, 99, 12);
        cur_tag = "R10";
        strobe(1); strobe(1); strobe(1); strobe(1); strobe(1); strobe(1);  // up to entry 7
        wait_idle();
        check_val("R10 queue drained", q.size(), 0);

        // R11: disable during a stall
        rdy_mode = 2;
        @(posedge clk); #2;
        cmd_ready = 1'b0;
        cur_tag = "R11";
        strobe(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_val("R11 stalled valid before disable", int'(cmd_valid), 1);
        @(posedge clk); #2;
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_val("R11 valid one cycle after disable", int'(cmd_valid), 0);
        q.delete(); tq.delete();
        rdy_mode = 0;
        set_timing(0, 1, 4, 10, 64, 12);
        repeat (3) @(posedge clk);
        cur_tag = "R11 restart";
        start_run();
        strobe(1);
        wait_idle();
        @(posedge clk); #2;
        en = 1'b0;
        repeat (3) @(posedge clk);

        // event schedule, 9/4 format, toggling ready, strobes mid-line
        wr_entry(0,  mk(8'h01,0,1, 8'h08,7,1, 0,0,0, 1));
        wr_entry(1,  31'd0);
        wr_entry(2,  mk(8'h21,0,1, 8'h08,7,1, 0,0,0, 1));
        wr_entry(3,  31'd0);
        wr_entry(4,  mk(8'h21,0,1, 8'h08,7,1, 0,0,0, 1));
        wr_entry(5,  31'd0);
        wr_entry(6,  mk(8'h21,0,1, 8'h19,2,1, 8'h3e,3,1, 0));
        wr_entry(7,  mk(8'h19,4,1, 0,0,0, 0,0,0, 0));
        wr_entry(8,  mk(8'h21,1,1, 8'h08,7,1, 0,0,0, 1));
        wr_entry(9,  31'd0);
        wr_entry(10, mk(8'h21,0,1, 8'h19,2,1, 8'h3e,3,1, 0));
        wr_entry(11, mk(8'h19,4,1, 0,0,0, 0,0,0, 0));
        set_timing(3, 0, 3, 5, 10, 4);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R8 sol_delay fmt3", int'(sol_delay), 18);
        rdy_mode = 1;
        cur_tag = "R6/R7/R9";
        start_run();
        cur_tag = "R4 held strobe";
        for (int s = 0; s < 7; s++) begin
            strobe(1);
            repeat (2) @(posedge clk);
            strobe(0);
        end
        wait_idle();
        check_val("R4 held strobes drained", q.size(), 0);
        @(posedge clk); #2;
        en = 1'b0;
        rdy_mode = 0;
        repeat (3) @(posedge clk);

        // 2/1 format with pulse schedule
        pulse_table();
        set_timing(2, 1, 8, 9, 20, 5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R8 sol_delay fmt2", int'(sol_delay), 16);
        cur_tag = "R6 fmt2";
        start_run();
        for (int s = 0; s < 7; s++) strobe(1);
        wait_idle();
        @(posedge clk); #2;
        en = 1'b0;
        set_timing(1, 1, 8, 9, 20, 5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R6 sol_delay fmt1", int'(sol_delay), 24);

        check_val("R1 final queue empty", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule